// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Sequencer

This block takes a small microcontroller into a low-power stop state and brings it back out. A stop request from software shuts off the oscillator and gates the peripheral, bus and CPU clock enables. The request is only accepted when no enabled peripheral interrupt is already pending. The stop state ends in one of two ways. An enabled peripheral interrupt ends it, or so does an active-low level on the external reset pin.

On wake-up the oscillator is restarted and a down-counter times the stabilization wait. Its length is picked by a 2-bit select input. The three clock domains are then re-enabled one cycle apart, peripheral first, then bus, then CPU. After an interrupt wake-up, the block pulses a single-cycle decision. One pulse tells the CPU to enter the interrupt routine. The other tells it to resume at the instruction after the stop. The choice depends on whether the CPU's level mask permits the interrupt. After a reset wake-up, the block holds the internal reset through the sequence and then pulses a reset-vector fetch request.

After a power-on reset, the same stabilization wait runs with every clock enabled, so that all internal state can be initialized. After an external-pin reset, the clocks stay gated during the wait. The oscillator and the CPU's save and fetch logic lie outside the block and are reached only through these pins. The block runs from a free-running reference clock. It has no data stream, so every pin is a plain control or status level.

Top module: `stop_wake_seq`

## Requirements
- R1: After `por_n` is released, the status reads 3 (oscillator wait) for exactly 2^EXP0 cycles. The wait length ignores `stab_sel`. During the wait `osc_en`, all three clock enables and `int_rst` are 1. The sequence then continues through the restart stages (status 4, 5, 6) with all clocks still on.
- R2: In RUN (status 0), if `stop_req` is high at a clock edge while `irq_pending` is low, the next status is STOPPED (status 1). In STOPPED, `osc_en`, `pclk_en`, `bclk_en` and `cpuclk_en` are all 0.
- R3: If `stop_req` is high in RUN while `irq_pending` is high, the request is ignored. The status stays 0 and all clock enables stay 1.
- R4: In STOPPED, a high `irq_pending` moves the status to 3 at the next edge. During the wait `osc_en` is 1, and all three clock enables and `int_rst` are 0.
- R5: A wake-up wait lasts exactly 2^EXPk cycles. Here k is the value of `stab_sel` at the edge where the wait begins. Select 0 to 3 map to EXP0 to EXP3.
- R6: After the wait, the status steps through 4, 5 and 6, one cycle each. The clock enables {cpu,bus,peripheral} read 001, then 011, then 111. No domain is enabled before the one ahead of it in this order.
- R7: After an interrupt wake-up, status 7 lasts one cycle. During it, `irq_take` is 1 if `irq_level_ok` was 1 at the edge entering status 7. Otherwise `irq_resume` is 1. The status then returns to 0.
- R8: `ext_rst_n` low, seen after a two-stage synchronizer, forces status 2 (reset hold) from any state. In reset hold `int_rst` is 1, `osc_en` is 1 and all three clock enables are 0. Releasing the pin starts an oscillator wait sized by `stab_sel`, with the clocks gated.
- R9: A reset-path sequence ends with status 7 for one cycle. During that cycle `vec_fetch_req` is 1 and `int_rst` is 0. `irq_take` and `irq_resume` stay 0, and the status then returns to 0.
- R10: An external reset asserted part-way through an interrupt wake-up abandons it. The full reset-path sequence then runs with a freshly timed wait.
- R11: At most one of `irq_take`, `irq_resume` and `vec_fetch_req` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| stop_req | input | 1 | Software stop write, one-cycle strobe |
| irq_pending | input | 1 | An enabled peripheral interrupt is pending |
| irq_level_ok | input | 1 | CPU level mask permits the pending interrupt |
| stab_sel | input | 2 | Stabilization length select |
| osc_en | output | 1 | Oscillator enable |
| pclk_en | output | 1 | Peripheral clock enable |
| bclk_en | output | 1 | Bus clock enable |
| cpuclk_en | output | 1 | CPU clock enable |
| int_rst | output | 1 | Internal reset |
| irq_take | output | 1 | One-cycle pulse: enter interrupt routine |
| irq_resume | output | 1 | One-cycle pulse: resume after stop instruction |
| vec_fetch_req | output | 1 | One-cycle pulse: fetch reset vector |
| status | output | 3 | 0 RUN, 1 STOPPED, 2 reset hold, 3 oscillator wait, 4/5/6 restart stages, 7 finish |

## Verification
The bench sets the four stabilization exponents to 3, 4, 5 and 6, which gives waits of 8, 16, 32 and 64 cycles. With these values every select setting can be timed to the exact cycle within a short run. A reset can also be dropped into the middle of a wait and the retimed wait measured. The wait length is checked for both the power-on case and the pin-reset case. The gating during the wait is compared between those two reset types on the same short counts.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STOP   = 3'd1,
    ST_RHOLD  = 3'd2,
    ST_OSCW   = 3'd3,
    ST_CLKP   = 3'd4,
    ST_CLKB   = 3'd5,
    ST_CLKC   = 3'd6,
    ST_FINISH = 3'd7
  } swk_state_e;

  localparam int NUM_DOMAINS = 3;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/swk_timer.sv
module swk_timer #(
  parameter int EXP0 = 10,
  parameter int EXP1 = 13,
  parameter int EXP2 = 15,
  parameter int EXP3 = 17
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       zero
);
  localparam int M01 = (EXP0 > EXP1) ? EXP0 : EXP1;
  localparam int M23 = (EXP2 > EXP3) ? EXP2 : EXP3;
  localparam int CW  = (M01 > M23) ? M01 : M23;

  localparam logic [CW-1:0] LEN0 = CW'((64'd1 << EXP0) - 64'd1);
  localparam logic [CW-1:0] LEN1 = CW'((64'd1 << EXP1) - 64'd1);
  localparam logic [CW-1:0] LEN2 = CW'((64'd1 << EXP2) - 64'd1);
  localparam logic [CW-1:0] LEN3 = CW'((64'd1 << EXP3) - 64'd1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_m1;

  always_comb begin
    case (sel)
      2'd0:    len_m1 = LEN0;
      2'd1:    len_m1 = LEN1;
      2'd2:    len_m1 = LEN2;
      default: len_m1 = LEN3;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                  cnt_q <= LEN0;
    else if (load)                cnt_q <= len_m1;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_pin_n,
  input  logic       stop_req,
  input  logic       irq_pending,
  input  logic       irq_level_ok,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic       tmr_run,
  output logic [2:0] state,
  output logic       osc_en,
  output logic [NUM_DOMAINS-1:0] dom_en,
  output logic       int_rst,
  output logic       irq_take,
  output logic       irq_resume,
  output logic       vec_fetch_req
);
  swk_state_e state_q, state_d;
  logic       rstpath_q, rstpath_d;
  logic       por_q, por_d;
  logic [NUM_DOMAINS-1:0] dom_d;
  logic       osc_q, irst_q, take_q, resume_q, vec_q;

  always_comb begin
    state_d   = state_q;
    rstpath_d = rstpath_q;
    por_d     = por_q;
    tmr_load  = 1'b0;
    if (!rst_pin_n) begin
      state_d   = ST_RHOLD;
      rstpath_d = 1'b1;
      por_d     = 1'b0;
    end else begin
      case (state_q)
        ST_RUN:    if (stop_req && !irq_pending) state_d = ST_STOP;
        ST_STOP:   if (irq_pending) begin
                     state_d   = ST_OSCW;
                     rstpath_d = 1'b0;
                     por_d     = 1'b0;
                     tmr_load  = 1'b1;
                   end
        ST_RHOLD:  begin
                     state_d  = ST_OSCW;
                     tmr_load = 1'b1;
                   end
        ST_OSCW:   if (tmr_zero) state_d = ST_CLKP;
        ST_CLKP:   state_d = ST_CLKB;
        ST_CLKB:   state_d = ST_CLKC;
        ST_CLKC:   state_d = ST_FINISH;
        default:   begin
                     state_d   = ST_RUN;
                     rstpath_d = 1'b0;
                     por_d     = 1'b0;
                   end
      endcase
    end
  end

  // Per-domain enable targets; a power-on sequence keeps every domain running.
  always_comb begin
    case (state_d)
      ST_RUN, ST_FINISH, ST_CLKC: dom_d = '1;
      ST_CLKP: dom_d = {{(NUM_DOMAINS-1){1'b0}}, 1'b1};
      ST_CLKB: dom_d = {1'b0, {(NUM_DOMAINS-1){1'b1}}};
      default: dom_d = '0;
    endcase
    if (por_d && (state_d inside {ST_OSCW, ST_CLKP, ST_CLKB})) dom_d = '1;
  end

  generate
    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_gate
      logic en_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) en_q <= 1'b1;
        else         en_q <= dom_d[g];
      end
      assign dom_en[g] = en_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q   <= ST_OSCW;
      rstpath_q <= 1'b1;
      por_q     <= 1'b1;
      osc_q     <= 1'b1;
      irst_q    <= 1'b1;
      take_q    <= 1'b0;
      resume_q  <= 1'b0;
      vec_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      rstpath_q <= rstpath_d;
      por_q     <= por_d;
      osc_q     <= (state_d != ST_STOP);
      irst_q    <= rstpath_d && (state_d inside {ST_RHOLD, ST_OSCW, ST_CLKP, ST_CLKB, ST_CLKC});
      take_q    <= (state_d == ST_FINISH) && !rstpath_d && irq_level_ok;
      resume_q  <= (state_d == ST_FINISH) && !rstpath_d && !irq_level_ok;
      vec_q     <= (state_d == ST_FINISH) && rstpath_d;
    end
  end

  assign tmr_run       = (state_q == ST_OSCW);
  assign state         = state_q;
  assign osc_en        = osc_q;
  assign int_rst       = irst_q;
  assign irq_take      = take_q;
  assign irq_resume    = resume_q;
  assign vec_fetch_req = vec_q;
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swk_pkg::*;
#(
  parameter int EXP0 = 10,
  parameter int EXP1 = 13,
  parameter int EXP2 = 15,
  parameter int EXP3 = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       stop_req,
  input  logic       irq_pending,
  input  logic       irq_level_ok,
  input  logic [1:0] stab_sel,
  output logic       osc_en,
  output logic       pclk_en,
  output logic       bclk_en,
  output logic       cpuclk_en,
  output logic       int_rst,
  output logic       irq_take,
  output logic       irq_resume,
  output logic       vec_fetch_req,
  output logic [2:0] status
);
  logic rst_pin_s;
  logic tmr_load, tmr_run, tmr_zero;
  logic [NUM_DOMAINS-1:0] dom_en;

  swk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(por_n), .din(ext_rst_n), .dout(rst_pin_s)
  );

  swk_timer #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) u_timer (
    .clk(clk), .arst_n(por_n), .load(tmr_load), .run(tmr_run),
    .sel(stab_sel), .zero(tmr_zero)
  );

  swk_fsm u_fsm (
    .clk(clk), .arst_n(por_n), .rst_pin_n(rst_pin_s),
    .stop_req(stop_req), .irq_pending(irq_pending), .irq_level_ok(irq_level_ok),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_run(tmr_run),
    .state(status), .osc_en(osc_en), .dom_en(dom_en), .int_rst(int_rst),
    .irq_take(irq_take), .irq_resume(irq_resume), .vec_fetch_req(vec_fetch_req)
  );

  assign pclk_en   = dom_en[0];
  assign bclk_en   = dom_en[1];
  assign cpuclk_en = dom_en[2];
endmodule

// File: rtl/swk_checker.sv
module swk_checker (
  input logic       clk,
  input logic       por_n,
  input logic       stop_req,
  input logic       irq_pending,
  input logic       osc_en,
  input logic       pclk_en,
  input logic       bclk_en,
  input logic       cpuclk_en,
  input logic       int_rst,
  input logic       irq_take,
  input logic       irq_resume,
  input logic       vec_fetch_req,
  input logic [2:0] status
);
  p_stop_gated_r2: assert property (@(posedge clk) disable iff (!por_n)
    (status == 3'd1) |-> (!osc_en && !pclk_en && !bclk_en && !cpuclk_en));

  p_stop_refused_r3: assert property (@(posedge clk) disable iff (!por_n)
    (status == 3'd0 && stop_req && irq_pending) |=> (status != 3'd1));

  p_bus_after_periph_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bclk_en) |-> $past(pclk_en));

  p_cpu_after_bus_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpuclk_en) |-> $past(bclk_en));

  p_periph_after_wait_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pclk_en) |-> $past(status) == 3'd3);

  p_take_in_finish_r7: assert property (@(posedge clk) disable iff (!por_n)
    (irq_take || irq_resume) |-> (status == 3'd7 && !int_rst));

  p_vec_released_r9: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch_req |-> (status == 3'd7 && !int_rst) ##1 (status == 3'd0));

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({irq_take, irq_resume, vec_fetch_req}));
endmodule

bind stop_wake_seq swk_checker u_swk_checker (
  .clk(clk), .por_n(por_n), .stop_req(stop_req), .irq_pending(irq_pending),
  .osc_en(osc_en), .pclk_en(pclk_en), .bclk_en(bclk_en), .cpuclk_en(cpuclk_en),
  .int_rst(int_rst), .irq_take(irq_take), .irq_resume(irq_resume),
  .vec_fetch_req(vec_fetch_req), .status(status)
);

// File: tb/stop_wake_seq_bench.sv
`timescale 1ns/1ps
module stop_wake_seq_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, stop_req = 1'b0;
  logic irq_pending = 1'b0, irq_level_ok = 1'b0;
  logic [1:0] stab_sel = 2'd0;
  logic osc_en, pclk_en, bclk_en, cpuclk_en, int_rst;
  logic irq_take, irq_resume, vec_fetch_req;
  logic [2:0] status;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  stop_wake_seq #(.EXP0(3), .EXP1(4), .EXP2(5), .EXP3(6)) u_stop_wake_seq (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .stop_req(stop_req),
    .irq_pending(irq_pending), .irq_level_ok(irq_level_ok), .stab_sel(stab_sel),
    .osc_en(osc_en), .pclk_en(pclk_en), .bclk_en(bclk_en), .cpuclk_en(cpuclk_en),
    .int_rst(int_rst), .irq_take(irq_take), .irq_resume(irq_resume),
    .vec_fetch_req(vec_fetch_req), .status(status)
  );

  function automatic logic [2:0] clks();
    return {cpuclk_en, bclk_en, pclk_en};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_status(int s, int lim);
    for (int i = 0; i < lim && status != 3'(s); i++) @(negedge clk);
  endtask

  // Counts wait cycles from the current negedge; checks clocks/reset every cycle.
  task automatic time_wait(string req, int exp_len, logic [2:0] exp_clk, logic exp_rst);
    int n = 0; int bad = 0;
    while (status == 3'd3 && n < 1000) begin
      if (clks() != exp_clk || int_rst != exp_rst || !osc_en) bad++;
      n++;
      @(negedge clk);
    end
    chk(req, "wait length", n, exp_len);
    chk(req, "bad clock/reset cycles during wait", bad, 0);
  endtask

  task automatic tail(string req, logic por, logic rstp, logic ok);
    chk("R6", "stage P status", status, 4);
    chk("R6", "stage P clocks", clks(), por ? 7 : 1);
    step();
    chk("R6", "stage B status", status, 5);
    chk("R6", "stage B clocks", clks(), por ? 7 : 3);
    step();
    chk("R6", "stage C status", status, 6);
    chk("R6", "stage C clocks", clks(), 7);
    step();
    chk(req, "finish status", status, 7);
    chk(req, "vec_fetch_req", vec_fetch_req, rstp);
    chk(req, "irq_take", irq_take, !rstp && ok);
    chk(req, "irq_resume", irq_resume, !rstp && !ok);
    chk(req, "int_rst in finish", int_rst, 0);
    step();
    chk(req, "back to run", status, 0);
    chk(req, "pulses cleared", {irq_take, irq_resume, vec_fetch_req}, 0);
  endtask

  task automatic t_por();
    chk("R1", "reset status", status, 3);
    chk("R1", "reset clocks", clks(), 7);
    stab_sel = 2'd3;
    por_n = 1'b1;
    time_wait("R1", 8, 3'b111, 1'b1);
    tail("R9", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic do_stop();
    stop_req = 1'b1; step(); stop_req = 1'b0;
    chk("R2", "stopped status", status, 1);
    chk("R2", "osc off", osc_en, 0);
    chk("R2", "clocks off", clks(), 0);
    step(3);
    chk("R2", "still stopped", status, 1);
  endtask

  task automatic t_wake(logic [1:0] sel, int len, logic ok, string req);
    do_stop();
    stab_sel = sel; irq_level_ok = ok; irq_pending = 1'b1;
    step();
    chk("R4", "wait entered", status, 3);
    chk("R4", "int_rst low", int_rst, 0);
    stab_sel = ~sel;
    time_wait("R5", len, 3'b000, 1'b0);
    irq_pending = 1'b0;
    tail(req, 1'b0, 1'b0, ok);
  endtask

  task automatic t_refuse();
    irq_pending = 1'b1; stop_req = 1'b1; step(); stop_req = 1'b0;
    chk("R3", "stays in run", status, 0);
    chk("R3", "clocks on", clks(), 7);
    step(2);
    chk("R3", "still run", status, 0);
    chk("R3", "osc on", osc_en, 1);
    irq_pending = 1'b0;
  endtask

  task automatic t_ext_reset_run();
    ext_rst_n = 1'b0;
    wait_status(2, 6);
    chk("R8", "reset hold", status, 2);
    chk("R8", "hold clocks", clks(), 0);
    chk("R8", "hold int_rst", int_rst, 1);
    chk("R8", "hold osc", osc_en, 1);
    stab_sel = 2'd1;
    ext_rst_n = 1'b1;
    wait_status(3, 6);
    time_wait("R8", 16, 3'b000, 1'b1);
    tail("R9", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_reset_mid_wake();
    do_stop();
    stab_sel = 2'd3; irq_level_ok = 1'b1; irq_pending = 1'b1;
    step(); irq_pending = 1'b0;
    step(10);
    chk("R10", "in wake wait", status, 3);
    ext_rst_n = 1'b0;
    wait_status(2, 6);
    chk("R10", "aborted to hold", status, 2);
    chk("R10", "clocks gated", clks(), 0);
    stab_sel = 2'd2;
    step(2);
    ext_rst_n = 1'b1;
    wait_status(3, 6);
    time_wait("R10", 32, 3'b000, 1'b1);
    tail("R10", 1'b0, 1'b1, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    t_por();
    t_wake(2'd2, 32, 1'b1, "R7");
    t_wake(2'd0, 8, 1'b0, "R7");
    t_refuse();
    t_ext_reset_run();
    t_reset_mid_wake();
    t_wake(2'd3, 64, 1'b1, "R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule